// File: doc/BRIEF.md
# Dual-Bank Interrupt Flag Aggregator

This block gathers single-cycle event pulses from the digital part of an analog front end into two flag banks of 32 bits each. Each bank has its own enable-select register and its own sticky flag register. A flag bit is captured only when the matching select bit of that bank is set. One polarity register and one write-one-to-clear register serve both banks.

Only bank 0 drives the interrupt line toward the host processor. Bank 1 is read by polling. The host is expected to detect a falling edge on the line. Four custom sources sit at bit positions 9 to 12. They are raised only by a sequencer, which writes a small general-interrupt status register. The host cannot write that register.

Source bit map: 0 ADC result, 1 DFT result, 2 sinc2 ready, 3 temperature, 4 ADC minimum fail, 5 ADC maximum fail, 6 ADC delta fail, 7 mean, 9–12 custom 0–3, 13 bootload done, 15 end of sequence, 16 sequencer timeout finished, 17 timeout command error, 23 FIFO full, 24 FIFO empty, 25 FIFO threshold, 26 FIFO overflow, 27 FIFO underflow, 29 outlier, 31 attempt to break (a sequence B request that arrived while sequence A was running and was dropped). Bits 8, 14, 18–22, 28 and 30 are unused.

Register addresses on `reg_addr`: 0 select bank 0, 1 select bank 1, 2 flags bank 0 (read-only), 3 flags bank 1 (read-only), 4 polarity (bit 0), 5 clear (write-only), 6 general status (bits 3:0).

Top module: `irq_flag_aggregator`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is 0.
- R2: A host write to address 0 or 1 loads that bank's select register. The register reads back the written value with the unused and unimplemented bits forced to zero.
- R3: An `evt_i` pulse on a hardware source bit sets the matching flag bit, in each bank whose select bit for that source is set, at the next clock edge. A bank whose select bit is clear does not capture the event.
- R4: Flags stay set until the host writes 1 to the matching bit of the clear register (address 5). That write clears the bit in both banks at the next edge.
- R5: If an event and a clear hit the same flag bit in the same cycle, the flag ends set.
- R6: Bank 1 flags never change `irq_o`.
- R7: `irq_o` equals, one cycle late, the OR over all bits of (bank 0 flags AND bank 0 select), XORed with polarity bit 0. Clearing a select bit therefore masks a flag that is already set from the line.
- R8: A sequencer write (`seq_wr`) stores `seq_wdata` in the general status register, which reads back at address 6. Each 1 in bit k raises custom source 9+k in the banks that enable it. `evt_i` bits 9–12 have no effect.
- R9: Host writes to address 6 leave the general status register unchanged and raise no flag.
- R10: Bits 8, 14, 18–22, 28 and 30 never set and always read zero in the select and flag registers.
- R11: The clear register reads zero, and host writes to the flag addresses (2, 3) change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| seq_wr | input | 1 | Sequencer write strobe for the general status register |
| seq_wdata | input | 4 | Sequencer write data |
| evt_i | input | 32 | Event pulses from the hardware sources |
| irq_o | output | 1 | Interrupt line from bank 0 |

## Verification
Flags, select, polarity and the general status register change at the first clock edge after the stimulus. Because reads are combinational, their new values can be read half a cycle later. `irq_o` passes through one more register, so it is due one edge after the flag, select or polarity value it depends on. The bench drives every input on the falling edge and reads just after the next falling edge. Line checks wait one further falling edge, so each sample falls in the exact cycle where the result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned SRC_W  = 32;
    localparam int unsigned NBANK  = 2;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CUST_N = 4;
    localparam int unsigned CUST_LO = 9;

    localparam logic [SRC_W-1:0] UNUSED_MASK =
        (32'h1 << 8) | (32'h1 << 14) | (32'h1F << 18) | (32'h1 << 28) | (32'h1 << 30);
    localparam logic [SRC_W-1:0] CUST_MASK = ((32'h1 << CUST_N) - 32'h1) << CUST_LO;
    localparam logic [SRC_W-1:0] IMPL_MASK = ~UNUSED_MASK;
    localparam logic [SRC_W-1:0] HW_MASK   = IMPL_MASK & ~CUST_MASK;

    typedef enum logic [ADDR_W-1:0] {
        A_SEL0  = 3'd0,
        A_SEL1  = 3'd1,
        A_FLAG0 = 3'd2,
        A_FLAG1 = 3'd3,
        A_POL   = 3'd4,
        A_CLR   = 3'd5,
        A_GEN   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [SRC_W-1:0] sel;
        logic [SRC_W-1:0] flag;
    } bank_st_t;

    typedef struct packed {
        logic              pol;
        logic [CUST_N-1:0] gen;
    } ctrl_st_t;

endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SRC_W-1:0] sel_wdata,
    input  logic [SRC_W-1:0] clr_mask,
    input  logic [SRC_W-1:0] src_evt,
    output logic [SRC_W-1:0] sel_q,
    output logic [SRC_W-1:0] flag_q
);

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_we) begin
            st_d.sel = sel_wdata & IMPL_MASK;
        end
        // events override a clear in the same cycle
        st_d.flag = ((st_q.flag & ~clr_mask) | (src_evt & st_q.sel)) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q  = st_q.sel;
    assign flag_q = st_q.flag;

endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] flag,
    input  logic [SRC_W-1:0] sel,
    input  logic             pol,
    output logic             irq_o
);

    logic line_d, line_q;

    always_comb begin
        line_d = (|(flag & sel)) ^ pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else begin
            line_q <= line_d;
        end
    end

    assign irq_o = line_q;

endmodule

// File: rtl/irq_flag_aggregator.sv
module irq_flag_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    input  logic              seq_wr,
    input  logic [CUST_N-1:0] seq_wdata,
    input  logic [SRC_W-1:0]  evt_i,
    output logic              irq_o
);

    ctrl_st_t         ctl_d, ctl_q;
    logic [SRC_W-1:0] clr_mask;
    logic [SRC_W-1:0] src_evt;
    logic [SRC_W-1:0] cust_evt;
    logic [SRC_W-1:0] bank_sel  [NBANK];
    logic [SRC_W-1:0] bank_flag [NBANK];

    always_comb begin
        ctl_d    = ctl_q;
        clr_mask = '0;
        cust_evt = '0;
        if (reg_wr && reg_addr == A_POL) begin
            ctl_d.pol = reg_wdata[0];
        end
        if (reg_wr && reg_addr == A_CLR) begin
            clr_mask = reg_wdata;
        end
        if (seq_wr) begin
            ctl_d.gen = seq_wdata;
            cust_evt  = {{(SRC_W-CUST_N){1'b0}}, seq_wdata} << CUST_LO;
        end
        src_evt = (evt_i & HW_MASK) | cust_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        irq_agg_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_we    (reg_wr && (reg_addr == ADDR_W'(A_SEL0 + b))),
            .sel_wdata (reg_wdata),
            .clr_mask  (clr_mask),
            .src_evt   (src_evt),
            .sel_q     (bank_sel[b]),
            .flag_q    (bank_flag[b])
        );
    end

    irq_agg_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (bank_flag[0]),
        .sel   (bank_sel[0]),
        .pol   (ctl_q.pol),
        .irq_o (irq_o)
    );

    always_comb begin
        case (reg_addr)
            A_SEL0:  reg_rdata = bank_sel[0];
            A_SEL1:  reg_rdata = bank_sel[1];
            A_FLAG0: reg_rdata = bank_flag[0];
            A_FLAG1: reg_rdata = bank_flag[1];
            A_POL:   reg_rdata = {{(SRC_W-1){1'b0}}, ctl_q.pol};
            A_GEN:   reg_rdata = {{(SRC_W-CUST_N){1'b0}}, ctl_q.gen};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [SRC_W-1:0]  reg_wdata,
    input logic              seq_wr,
    input logic [SRC_W-1:0]  evt_i,
    input logic [SRC_W-1:0]  sel0,
    input logic [SRC_W-1:0]  sel1,
    input logic [SRC_W-1:0]  flag0,
    input logic [SRC_W-1:0]  flag1,
    input logic              pol,
    input logic [CUST_N-1:0] gen,
    input logic              irq_o
);

    logic [SRC_W-1:0] host_clr;
    assign host_clr = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;

    // R3: a new flag bit needs its select bit in the previous cycle
    assert_flag_needs_sel0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag0 & ~$past(flag0) & ~$past(sel0)) == '0);
    assert_flag_needs_sel1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag1 & ~$past(flag1) & ~$past(sel1)) == '0);

    // R4: a flag bit drops only after a host clear of that bit
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag0) & ~flag0 & ~$past(host_clr)) |
         ($past(flag1) & ~flag1 & ~$past(host_clr))) == '0);

    // R5: an enabled hardware event always lands, even with a clear present
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i & HW_MASK & sel0) & ~flag0) == '0);

    // R7 and R6: the line follows bank 0 state and polarity one cycle late
    assert_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past((|(flag0 & sel0)) ^ pol));

    // R9: the general status register moves only on sequencer writes
    assert_gen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_wr |=> $stable(gen));

    // R10: unused positions stay zero
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag0 | flag1 | sel0 | sel1) & UNUSED_MASK) == '0);

endmodule

bind irq_flag_aggregator irq_agg_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .seq_wr    (seq_wr),
    .evt_i     (evt_i),
    .sel0      (bank_sel[0]),
    .sel1      (bank_sel[1]),
    .flag0     (bank_flag[0]),
    .flag1     (bank_flag[1]),
    .pol       (ctl_q.pol),
    .gen       (ctl_q.gen),
    .irq_o     (irq_o)
);

// File: tb/irq_flag_aggregator_tb_top.sv
module irq_flag_aggregator_tb_top;

    localparam logic [31:0] UNUSED = 32'h507C_4100;
    localparam logic [31:0] CUST   = 32'h0000_1E00;
    localparam logic [31:0] IMPL   = ~UNUSED;
    localparam logic [31:0] HW     = IMPL & ~CUST;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_wr = 1'b0;
    logic [3:0]  seq_wdata = '0;
    logic [31:0] evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_aggregator dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .seq_wr    (seq_wr),
        .seq_wdata (seq_wdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        @(negedge clk);
        #1;
        chk(tag, {31'd0, irq_o}, {31'd0, exp});
    endtask

    task automatic clear_all();
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset readback", d, 32'h0);
        end
        chk("R1 reset line", {31'd0, irq_o}, 32'h0);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R2 sel0 readback masked", d, IMPL);
        chk("R10 sel0 unused zero", d & UNUSED, 32'h0);
        wr(3'd1, 32'h0000_00A5);
        rd(3'd1, d); chk("R2 sel1 readback", d, 32'h0000_00A5);
        rd(3'd0, d); chk("R2 sel0 untouched by sel1 write", d, IMPL);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        // sel0 = all, sel1 = 0xA5
        pulse(32'h0000_0002);
        rd(3'd2, d); chk("R3 bank0 captures enabled event", d, 32'h0000_0002);
        rd(3'd3, d); chk("R3 bank1 ignores disabled event", d, 32'h0);
        chk_irq("R7 line active after bank0 flag", 1'b1);
        clear_all();
        chk_irq("R7 line idle after clear", 1'b0);
        // bank1 only
        wr(3'd0, 32'h0);
        pulse(32'h0000_0020);
        rd(3'd3, d); chk("R3 bank1 captures bit5", d, 32'h0000_0020);
        rd(3'd2, d); chk("R3 bank0 disabled", d, 32'h0);
        chk_irq("R6 bank1 flag leaves line idle", 1'b0);
        clear_all();
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        pulse(32'h8200_0001);
        repeat (5) @(negedge clk);
        rd(3'd2, d); chk("R4 bank0 flags persist", d, 32'h8200_0001);
        rd(3'd3, d); chk("R4 bank1 flags persist", d, 32'h8200_0001);
        wr(3'd5, 32'h8000_0001);
        rd(3'd2, d); chk("R4 clear bank0 selected bits", d, 32'h0200_0000);
        rd(3'd3, d); chk("R4 clear bank1 selected bits", d, 32'h0200_0000);
        clear_all();
    endtask

    task automatic t_event_wins();
        logic [31:0] d;
        @(negedge clk);
        evt_i = 32'h0001_0000;
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0001_0008;
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd2, d); chk("R5 event beats clear", d, 32'h0001_0000);
        clear_all();
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        wr(3'd4, 32'h1);
        rd(3'd4, d); chk("R7 polarity readback", d, 32'h1);
        chk_irq("R7 inverted idle level", 1'b1);
        pulse(32'h0000_0080);
        chk_irq("R7 inverted active level", 1'b0);
        wr(3'd4, 32'h0);
        chk_irq("R7 normal active level", 1'b1);
        wr(3'd0, 32'h0);
        chk_irq("R7 select mask hides set flag", 1'b0);
        rd(3'd2, d); chk("R7 flag kept after select drop", d, 32'h0000_0080);
        wr(3'd0, 32'hFFFF_FFFF);
        clear_all();
    endtask

    task automatic t_custom();
        logic [31:0] d;
        @(negedge clk);
        seq_wr = 1'b1; seq_wdata = 4'b0101;
        @(negedge clk);
        seq_wr = 1'b0; seq_wdata = '0;
        rd(3'd6, d); chk("R8 general status readback", d, 32'h5);
        rd(3'd2, d); chk("R8 custom flags 9 and 11", d, 32'h0000_0A00);
        clear_all();
        pulse(CUST);
        rd(3'd2, d); chk("R8 evt_i custom bits ignored", d, 32'h0);
        wr(3'd6, 32'hF);
        rd(3'd6, d); chk("R9 host write to general status ignored", d, 32'h5);
        rd(3'd2, d); chk("R9 host write raises no flag", d, 32'h0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        pulse(32'hFFFF_FFFF);
        rd(3'd2, d); chk("R10 all-ones event bank0", d, HW);
        rd(3'd3, d); chk("R10 all-ones event bank1", d, HW);
        clear_all();
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        pulse(32'h0000_0004);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R11 flag0 not host writable", d, 32'h0000_0004);
        rd(3'd3, d); chk("R11 flag1 not host writable", d, 32'h0000_0004);
        rd(3'd5, d); chk("R11 clear reads zero", d, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_enable();
        t_sticky();
        t_event_wins();
        t_polarity();
        t_custom();
        t_unused();
        t_readonly();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule